// File: doc/BRIEF.md
# Overlapping-Frame Hamming Window Multiplier

This block sits between an audio sample source and a frequency transform. It keeps a sliding history of the most recent 1440 audio samples in a chain of registers. Once a programmable number of new samples (the hop) has arrived since the previous pass, it freezes a copy of that history and streams out a 2048-point windowed frame, one product per clock. Each product is one stored sample multiplied by a Hamming coefficient that a read-only table supplies for the same index.

Frame positions 1440 to 2047 carry no sample and have a zero coefficient, so the transform sees one 1440-sample frame zero-padded to 2048 points. With the default hop of 720 samples, successive frames overlap by half. Samples keep arriving while a pass runs. They shift into the live history, and the pass reads only the frozen copy. A hop that completes during a pass is held and launches the next pass as soon as the current one ends.

Top module: `hamming_frame_win`

## Requirements
- R1: While reset is held and after it is released, out_valid, out_first and out_last stay low until the first pass starts.
- R2: In a frame, position k (0 to 1439) holds the sample that arrived 1439-k samples before the newest sample captured, so position 0 is the oldest and 1439 the newest. Positions for which no sample has arrived since reset hold zero.
- R3: A pass starts only after hop_len samples have been accepted since the previous pass started, counting samples that arrive during a pass. A hop_len of 0 behaves as 1.
- R4: The output at position k below 1440 is (s*c + 2^14) >> 15, arithmetic, saturated to the signed 16-bit range. Here s is the signed sample and c is the unsigned coefficient round(32768*(0.54 - 0.46*cos(2*pi*k/1439))).
- R5: Outputs at positions 1440 to 2047 are exactly zero.
- R6: A frame is 2048 consecutive cycles with out_valid high. out_first is high only in its first cycle and out_last only in its last. out_valid is low outside a frame.
- R7: out_first rises on the third rising clock edge after the edge that accepts the sample completing the hop.
- R8: Samples accepted while a pass runs do not change the frame being output.
- R9: If the hop completes during a pass, the next frame's out_first comes exactly 2049 cycles after the previous frame's out_first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hop_len | input | 16 | New samples required between passes (0 behaves as 1) |
| in_valid | input | 1 | A sample is accepted on this edge |
| in_sample | input | 16 | Signed audio sample |
| out_valid | output | 1 | out_data carries a windowed product |
| out_first | output | 1 | Marks frame position 0 |
| out_last | output | 1 | Marks frame position 2047 |
| out_data | output | 16 | Signed windowed product |

## Verification
A pass is launched one edge after the hop-completing sample. The coefficient and the history reads are each registered once, and the product is registered again, so position k of a frame appears on the (k+3)-th edge after the triggering sample. For every frame, the bench records the observation cycle it expects for out_first and the count of samples the frame must contain. It then compares each of the 2048 products against its own reference at the matching cycle, sampling on the falling edge. For a hop that completes during a pass, the expected start is the previous frame's start plus 2049 cycles.

// File: rtl/hfw_pkg.sv
package hfw_pkg;

  // Fixed-point angle constants, scaled by 2^28
  localparam longint TWO_PI_Q28  = 64'sd1686629713;
  localparam longint PI_Q28      = 64'sd843314857;
  localparam longint HALF_PI_Q28 = 64'sd421657428;
  localparam longint ONE_Q28     = 64'sd268435456;
  localparam longint A0_Q28      = 64'sd144955146; // 0.54

  // Cosine of x (Q28, 0..pi/2) by a truncated series
  function automatic longint cos_q28(input longint x);
    longint x2;
    longint term;
    longint acc;
    x2   = (x * x) >>> 28;
    term = ONE_Q28;
    acc  = term;
    for (int k = 1; k <= 6; k++) begin
      term = -((term * x2) >>> 28) / longint'((2 * k - 1) * (2 * k));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Unsigned Q1.15 Hamming coefficient for index n of a frame of length len
  function automatic longint hamming_q15(input longint n, input longint len);
    longint den;
    longint num;
    longint x;
    longint c;
    bit     neg;
    if (n >= len || len < 2) return 0;
    den = len - 1;
    num = n;
    if (2 * num > den) num = den - num;
    x   = (TWO_PI_Q28 * num) / den;
    neg = 1'b0;
    if (x > HALF_PI_Q28) begin
      x   = PI_Q28 - x;
      neg = 1'b1;
    end
    c = cos_q28(x);
    if (neg) c = -c;
    return (A0_Q28 - (c * 46) / 100 + 64'sd4096) >>> 13;
  endfunction

  // Round half up by frac bits, then clamp to a signed width-bit range
  function automatic longint round_sat(input longint p, input int frac, input int width);
    longint r;
    longint hi;
    longint lo;
    r  = (p + (longint'(1) <<< (frac - 1))) >>> frac;
    hi = (longint'(1) <<< (width - 1)) - 1;
    lo = -(longint'(1) <<< (width - 1));
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

endpackage

// File: rtl/hfw_hop_ctl.sv
module hfw_hop_ctl #(
  parameter int HOP_W = 16,
  localparam int CNT_W = HOP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HOP_W-1:0] hop_len,
  input  logic             in_valid,
  input  logic             busy,
  output logic             start,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] hop_eff
);

  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W:0] cnt_nxt;

  assign hop_eff = (hop_len == '0) ? CNT_W'(1) : {1'b0, hop_len};
  assign start   = !busy && (cnt_q >= hop_eff);

  always_comb begin
    cnt_nxt = {1'b0, cnt_q};
    if (start)    cnt_nxt = cnt_nxt - {1'b0, hop_eff};
    if (in_valid) cnt_nxt = cnt_nxt + 1'b1;
    if (cnt_nxt > CNT_MAX) cnt_nxt = CNT_MAX;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt[CNT_W-1:0];
  end

endmodule

// File: rtl/hfw_history.sv
module hfw_history #(
  parameter int DEPTH    = 2048,
  parameter int FRAME    = 1440,
  parameter int SAMPLE_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  input  logic                       capture,
  input  logic [AW-1:0]              rd_addr,
  output logic signed [SAMPLE_W-1:0] rd_q
);

  logic signed [SAMPLE_W-1:0] hist [FRAME];
  logic signed [SAMPLE_W-1:0] snap [FRAME];

  // Live shift chain: index 0 is the oldest sample, FRAME-1 the newest
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < FRAME; k++) hist[k] <= '0;
    end else if (in_valid) begin
      for (int k = 0; k < FRAME - 1; k++) hist[k] <= hist[k + 1];
      hist[FRAME - 1] <= in_sample;
    end
  end

  // Frozen copy read by a pass
  always_ff @(posedge clk) begin
    if (capture) begin
      for (int k = 0; k < FRAME; k++) snap[k] <= hist[k];
    end
  end

  // Registered read, matching the coefficient table latency; pad region reads zero
  always_ff @(posedge clk) begin
    if (!rst_n)                     rd_q <= '0;
    else if (32'(rd_addr) < FRAME)  rd_q <= snap[rd_addr];
    else                            rd_q <= '0;
  end

endmodule

// File: rtl/hfw_coef_rom.sv
module hfw_coef_rom #(
  parameter int DEPTH  = 2048,
  parameter int FRAME  = 1440,
  parameter int COEF_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     addr,
  output logic [COEF_W-1:0] coef_q
);

  logic [COEF_W-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      rom[i] = COEF_W'(hfw_pkg::hamming_q15(longint'(i), longint'(FRAME)));
  end

  always_ff @(posedge clk) coef_q <= rom[addr];

endmodule

// File: rtl/hfw_sequencer.sv
module hfw_sequencer #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr,
  output logic          s1_valid,
  output logic          s1_first,
  output logic          s1_last
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
    end else if (start) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (busy) begin
      addr <= addr + 1'b1;
      if (addr == LAST) busy <= 1'b0;
    end
  end

  // Flags for the cycle in which the registered reads are available
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
    end else begin
      s1_valid <= busy;
      s1_first <= busy && (addr == '0);
      s1_last  <= busy && (addr == LAST);
    end
  end

endmodule

// File: rtl/hamming_frame_win.sv
module hamming_frame_win #(
  parameter int DEPTH    = 2048,
  parameter int FRAME    = 1440,
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int HOP_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [HOP_W-1:0]           hop_len,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       out_valid,
  output logic                       out_first,
  output logic                       out_last,
  output logic signed [SAMPLE_W-1:0] out_data
);

  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = HOP_W + 1;
  localparam int FRAC  = COEF_W - 1;

  // Named internal events, also observed by the checker
  logic                       start_pulse;
  logic                       busy;
  logic [CNT_W-1:0]           cnt_q;
  logic [CNT_W-1:0]           hop_eff;
  logic [AW-1:0]              rd_addr;
  logic                       s1_valid;
  logic                       s1_first;
  logic                       s1_last;
  logic signed [SAMPLE_W-1:0] samp_q;
  logic [COEF_W-1:0]          coef_q;

  hfw_hop_ctl #(.HOP_W(HOP_W)) u_hop (
    .clk      (clk),
    .rst_n    (rst_n),
    .hop_len  (hop_len),
    .in_valid (in_valid),
    .busy     (busy),
    .start    (start_pulse),
    .cnt_q    (cnt_q),
    .hop_eff  (hop_eff)
  );

  hfw_sequencer #(.DEPTH(DEPTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_pulse),
    .busy     (busy),
    .addr     (rd_addr),
    .s1_valid (s1_valid),
    .s1_first (s1_first),
    .s1_last  (s1_last)
  );

  hfw_history #(.DEPTH(DEPTH), .FRAME(FRAME), .SAMPLE_W(SAMPLE_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .capture   (start_pulse),
    .rd_addr   (rd_addr),
    .rd_q      (samp_q)
  );

  hfw_coef_rom #(.DEPTH(DEPTH), .FRAME(FRAME), .COEF_W(COEF_W)) u_rom (
    .clk    (clk),
    .addr   (rd_addr),
    .coef_q (coef_q)
  );

  // Multiply, round and saturate into the output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      out_first <= s1_first;
      out_last  <= s1_last;
      out_data  <= SAMPLE_W'(hfw_pkg::round_sat(longint'(samp_q) * longint'(coef_q),
                                                FRAC, SAMPLE_W));
    end
  end

endmodule

// File: rtl/hfw_chk.sv
module hfw_chk #(
  parameter int DEPTH    = 2048,
  parameter int FRAME    = 1440,
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 17,
  localparam int AW = $clog2(DEPTH)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_pulse,
  input logic                busy,
  input logic [CNT_W-1:0]    cnt_q,
  input logic [CNT_W-1:0]    hop_eff,
  input logic                out_valid,
  input logic                out_first,
  input logic                out_last,
  input logic [SAMPLE_W-1:0] out_data
);

  logic [AW-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n)         pos <= '0;
    else if (out_valid) pos <= out_last ? '0 : pos + 1'b1;
  end

  // R6
  first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> (out_valid && pos == '0));

  // R6
  last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && pos == AW'(DEPTH - 1)));

  // R6
  frame_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);

  // R7
  launch_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> $past(start_pulse, 3));

  // R3
  hop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cnt_q) >= $past(hop_eff)));

  // R5
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && 32'(pos) >= FRAME) |-> (out_data == '0));

endmodule

bind hamming_frame_win hfw_chk #(
  .DEPTH(DEPTH), .FRAME(FRAME), .SAMPLE_W(SAMPLE_W), .CNT_W(HOP_W + 1)
) u_hfw_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_pulse (start_pulse),
  .busy        (busy),
  .cnt_q       (cnt_q),
  .hop_eff     (hop_eff),
  .out_valid   (out_valid),
  .out_first   (out_first),
  .out_last    (out_last),
  .out_data    (out_data)
);

// File: tb/hamming_frame_win_bench.sv
module hamming_frame_win_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 2048;
  localparam int FRAME      = 1440;
  localparam int LOG_MAX    = 4096;
  localparam int MAX_FR     = 16;
  localparam int WATCHDOG   = 150000;
  localparam real PI        = 3.14159265358979;

  // Stimulus vectors; sample n is PAT[n%16] - 7*n (16-bit wrap)
  localparam logic signed [15:0] PAT [16] = '{
    16'sd32767, -16'sd32768, 16'sd0, 16'sd1, -16'sd1, 16'sd12345, -16'sd12345, 16'sd16384,
    -16'sd16384, 16'sd255, -16'sd256, 16'sd30000, -16'sd30001, 16'sd7, 16'sd1000, -16'sd999
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [15:0]        hop_len = 16'd720;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic               out_valid;
  logic               out_first;
  logic               out_last;
  logic signed [15:0] out_data;

  hamming_frame_win u_hamming_frame_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .hop_len   (hop_len),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_first (out_first),
    .out_last  (out_last),
    .out_data  (out_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int ncyc = 0;
  int n_sent = 0;
  int last_n = 0;
  int frames_planned = 0;
  int frames_seen = 0;
  bit summary_done = 1'b0;
  logic signed [15:0] sent_log [LOG_MAX];
  int incl [MAX_FR];
  int exp_first [MAX_FR];
  string ftag [MAX_FR];

  function automatic logic signed [15:0] stim(input int n);
    return 16'(int'(PAT[n % 16]) - 7 * n);
  endfunction

  function automatic longint ref_coef(input int k);
    real a;
    if (k >= FRAME) return 0;
    a = 2.0 * PI * real'(k) / real'(FRAME - 1);
    return longint'($rtoi($floor((0.54 - 0.46 * $cos(a)) * 32768.0 + 0.5)));
  endfunction

  function automatic longint ref_out(input longint s, input int k);
    longint r;
    r = (s * ref_coef(k) + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int count);
    for (int i = 0; i < count; i++) begin
      in_valid  = 1'b1;
      in_sample = stim(n_sent);
      sent_log[n_sent] = stim(n_sent);
      @(posedge clk);
      last_n = ncyc;
      n_sent++;
      #1;
      in_valid = 1'b0;
    end
  endtask

  task automatic plan(input int first_at, input string tag);
    incl[frames_planned]      = n_sent;
    exp_first[frames_planned] = first_at;
    ftag[frames_planned]      = tag;
    frames_planned++;
  endtask

  task automatic idle(input int cycles);
    repeat (cycles) @(posedge clk);
    #1;
  endtask

  // Output monitor, away from the active edge
  bit in_frame = 1'b0;
  bit cmp_on = 1'b0;
  int pos = 0;
  int cur = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_first) begin
        check(!in_frame, "R6", "first flag inside a frame", 1, 0);
        if (frames_seen >= frames_planned) begin
          check(1'b0, "R3", "frame launched without a completed hop", frames_seen, frames_planned);
          cmp_on = 1'b0;
        end else begin
          cur = frames_seen;
          cmp_on = 1'b1;
          check(ncyc == exp_first[cur], ftag[cur], $sformatf("frame %0d first cycle", cur),
                ncyc, exp_first[cur]);
        end
        in_frame = 1'b1;
        pos = 0;
      end
      if (in_frame) begin
        if (!out_valid) begin
          check(1'b0, "R6", "valid dropped inside a frame", pos, DEPTH);
          in_frame = 1'b0;
          frames_seen++;
        end else begin
          if (cmp_on) begin
            longint s;
            longint e;
            int idx;
            idx = incl[cur] - FRAME + pos;
            s = (pos < FRAME && idx >= 0) ? longint'(sent_log[idx]) : 0;
            e = ref_out(s, pos);
            if (pos >= FRAME)
              check(out_data == 0, "R5", $sformatf("pad position %0d", pos), out_data, 0);
            else
              check((longint'(out_data) - e) <= 2 && (e - longint'(out_data)) <= 2,
                    "R4", $sformatf("%s frame %0d position %0d", ftag[cur] == "R8" ? "R8" : "R2",
                    cur, pos), out_data, e);
          end
          check(out_last == (pos == DEPTH - 1), "R6", $sformatf("last flag at %0d", pos),
                out_last, pos == DEPTH - 1);
          if (pos == DEPTH - 1) begin
            in_frame = 1'b0;
            frames_seen++;
          end else begin
            pos++;
          end
        end
      end else if (out_valid) begin
        check(1'b0, "R6", "valid outside a frame", 1, 0);
      end
    end
    ncyc++;
  end

  task automatic finish_run;
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    wait (ncyc > WATCHDOG);
    check(1'b0, "R6", "watchdog expired", ncyc, WATCHDOG);
    finish_run();
  end

  initial begin
    // R1: reset state
    idle(3);
    @(negedge clk);
    check(!out_valid && !out_first && !out_last, "R1", "outputs during reset",
          {out_valid, out_first, out_last}, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    idle(5);
    @(negedge clk);
    check(!out_valid, "R1", "valid after reset", out_valid, 0);
    #1;

    // R3: one short of the hop, no frame; R2 zero-filled older positions
    send(719);
    idle(20);
    check(frames_seen == 0, "R3", "frames before hop completes", frames_seen, 0);
    send(1);
    plan(last_n + 3, "R7");
    idle(2100);
    check(frames_seen == 1, "R2", "frames after first hop", frames_seen, 1);

    // R2: full overlapping frame
    send(720);
    plan(last_n + 3, "R2");
    idle(2100);
    check(frames_seen == 2, "R2", "frames after second hop", frames_seen, 2);

    // R8: samples arriving mid-pass leave the frame unchanged
    send(720);
    plan(last_n + 3, "R8");
    idle(100);
    send(300);
    idle(2000);
    check(frames_seen == 3, "R8", "frames after coherence pass", frames_seen, 3);
    // R3: mid-pass samples count toward the next hop
    send(419);
    idle(20);
    check(frames_seen == 3, "R3", "frames one short of hop", frames_seen, 3);
    send(1);
    plan(last_n + 3, "R3");
    idle(2100);
    check(frames_seen == 4, "R3", "frames after counted hop", frames_seen, 4);

    // R3: hop_len of 0 acts as 1
    hop_len = 16'd0;
    idle(5);
    check(frames_seen == 4, "R3", "frames with zero hop and no sample", frames_seen, 4);
    send(1);
    plan(last_n + 3, "R3");
    idle(2100);
    check(frames_seen == 5, "R3", "frames after zero hop", frames_seen, 5);

    // R9: second hop completes during a pass and launches right after it
    hop_len = 16'd4;
    idle(2);
    send(4);
    plan(last_n + 3, "R7");
    send(6);
    plan(exp_first[frames_planned - 1] + 2049, "R9");
    idle(4300);
    check(frames_seen == 7, "R9", "frames after pending hop", frames_seen, 7);
    idle(2200);
    check(frames_seen == 7, "R3", "no extra frame without a hop", frames_seen, 7);

    finish_run();
  end

endmodule